// File: doc/BRIEF.md
# CAN FD CRC Fixed-Stuff Unit

This unit handles the fixed stuff bits inside the CRC field of a CAN FD frame, one bit at a time. A fixed stuff bit stands before CRC bit 0 and before every CRC bit whose index is a multiple of four. Its value is always the complement of the bit that went onto the line just before it. In transmit mode the unit sits between the CRC shift register and the line. It passes CRC bits through and inserts the stuff bits on its own. While it does so it asks the shift register to hold for that bit time.

In receive mode the same slot sequence is applied to bits taken from the bus. Data bits go on to the CRC checker with a valid strobe. Stuff bits are dropped. A stuff bit that fails to invert its predecessor produces a stuff-error pulse. The unit counts CRC bits against the selected length, 17 or 21, and does not act on the field again until the field qualifier is removed. Bit timing, CRC arithmetic and dynamic stuffing outside the CRC field are handled by other logic.

Top module: `fd_crc_fixstuff`

## Requirements
- R1: With `crc_act` high, the n-th strobe of a field (n counted from 0) is a stuff slot when n mod 5 equals 0. It is a data slot otherwise. This continues until all CRC bits have been counted, so a stuff slot stands before each CRC bit whose index is a multiple of 4.
- R2: In transmit mode (`tx_en`=1), `tx_bit` in a stuff slot is the complement of the previous line bit. This includes the last bit sent before the field opened.
- R3: In transmit mode, on data slots, on slots after the field is complete, and while `crc_act` is low, `tx_bit` equals `ser_in`.
- R4: `tx_stall` is high exactly while the next slot of an open field in transmit mode is a stuff slot. It is high during that slot's strobe and low again after it, so the stall lasts one bit time. It is low in receive mode and while `crc_act` is low.
- R5: `crc_len21`=1 selects 21 CRC bits (6 stuff slots) and 0 selects 17 (5 stuff slots). Once the count is reached, further strobes in the same field produce no stuff slot, no stall and no receive strobe.
- R6: In receive mode (`tx_en`=0), `rx_crc_vld` is high in the same cycle as each strobe on a data slot, with `rx_crc_bit` equal to `ser_in`. It is low on stuff slots, after the field is complete, in transmit mode and between strobes.
- R7: In receive mode, `stuff_err` pulses high for one cycle, in the cycle after a stuff-slot strobe whose `ser_in` equals the previous line bit. Otherwise it stays low.
- R8: A low `crc_act` at any clock edge clears the slot count, so the next field again opens with a stuff slot.
- R9: After reset the previous-line-bit state is 1 (recessive) and all outputs that depend on state are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | 1 = transmit path, 0 = receive path |
| bit_stb | input | 1 | One-cycle strobe marking a new bit time |
| crc_act | input | 1 | High while the CRC field is in progress |
| crc_len21 | input | 1 | 1 = 21-bit CRC, 0 = 17-bit CRC |
| ser_in | input | 1 | CRC bit (transmit) or bus bit (receive) |
| tx_bit | output | 1 | Bit to put on the line |
| tx_stall | output | 1 | Hold request to the upstream CRC shifter |
| rx_crc_bit | output | 1 | Destuffed bit toward the CRC checker |
| rx_crc_vld | output | 1 | Strobe for `rx_crc_bit` |
| stuff_err | output | 1 | One-cycle fixed-stuff error pulse |

## Verification
`tx_bit`, `tx_stall`, `rx_crc_bit` and `rx_crc_vld` are decoded from state without a register, so each is due in the cycle that carries the strobe. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the rising edge that advances the slot count. `stuff_err` is registered and is due one cycle later. The bench checks it after the following falling edge and expects it low on every gap cycle that comes after.

// File: rtl/fdfs_pkg.sv
package fdfs_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_STUFF = 2'd1,
    SLOT_DATA  = 2'd2,
    SLOT_DONE  = 2'd3
  } slot_e;

  // number of CRC bits for the selected length
  function automatic int unsigned field_len(input logic sel_long,
                                            input int unsigned len_s,
                                            input int unsigned len_l);
    return sel_long ? len_l : len_s;
  endfunction

  // a stuff slot is owed before CRC bit index n when n is a group multiple
  function automatic logic grp_edge(input int unsigned n, input int unsigned grp);
    return (n % grp) == 0;
  endfunction

  // kind of the slot that the next strobe will occupy
  function automatic slot_e slot_kind(input logic act, input int unsigned cnt,
                                      input logic pend, input int unsigned len);
    if (!act)        return SLOT_IDLE;
    if (cnt >= len)  return SLOT_DONE;
    if (pend)        return SLOT_STUFF;
    return SLOT_DATA;
  endfunction

endpackage

// File: rtl/fdfs_slot_ctr.sv
module fdfs_slot_ctr
  import fdfs_pkg::*;
#(
  parameter int unsigned LEN_S = 17,
  parameter int unsigned LEN_L = 21,
  parameter int unsigned GRP   = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_stb,
  input  logic  crc_act,
  input  logic  crc_len21,
  output slot_e slot,
  output logic  ev_stuff,
  output logic  ev_data
);
  localparam int unsigned CW = $clog2(LEN_L + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  int unsigned   len_w;

  always_comb len_w = field_len(crc_len21, LEN_S, LEN_L);
  always_comb slot  = slot_kind(crc_act, 32'(cnt_q), pend_q, len_w);

  assign ev_stuff = bit_stb && (slot == SLOT_STUFF);
  assign ev_data  = bit_stb && (slot == SLOT_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n || !crc_act) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (ev_stuff) begin
      pend_q <= 1'b0;
    end else if (ev_data) begin
      cnt_q  <= cnt_q + 1'b1;
      pend_q <= grp_edge(32'(cnt_q) + 32'd1, GRP);
    end
  end

  // R5: the CRC bit count never passes the longest field
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= LEN_L);

  // R1: each data slot advances the count by exactly one
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> cnt_q == $past(cnt_q) + 1'b1);

  // R1: a stuff slot is never followed directly by another stuff slot
  p_stuff_then_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stuff |=> slot != SLOT_STUFF);

  // R8: a closed field leaves the counter cleared with a stuff slot owed
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_act |=> (cnt_q == '0) && pend_q);

endmodule

// File: rtl/fdfs_tx_ins.sv
module fdfs_tx_ins
  import fdfs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_en,
  input  logic  bit_stb,
  input  slot_e slot,
  input  logic  ser_in,
  input  logic  line_q,
  output logic  tx_bit,
  output logic  tx_stall
);
  logic ins_w;

  assign ins_w    = tx_en && (slot == SLOT_STUFF);
  assign tx_stall = ins_w;
  assign tx_bit   = ins_w ? ~line_q : ser_in;

  // R4: the hold request lasts a single bit time
  p_stall_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stall && bit_stb |=> !tx_stall);

endmodule

// File: rtl/fdfs_rx_chk.sv
module fdfs_rx_chk #(
  parameter bit ERR_REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic ev_stuff,
  input  logic ev_data,
  input  logic ser_in,
  input  logic line_q,
  output logic rx_crc_bit,
  output logic rx_crc_vld,
  output logic stuff_err
);
  logic bad_now;

  assign rx_crc_bit = ser_in;
  assign rx_crc_vld = rx_en && ev_data;
  assign bad_now    = rx_en && ev_stuff && (ser_in == line_q);

  generate
    if (ERR_REG) begin : g_err_reg
      logic err_q;
      always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad_now;
      end
      assign stuff_err = err_q;

      // R7: an error pulse is always caused by a receive stuff slot
      p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> $past(rx_en && ev_stuff));
    end else begin : g_err_comb
      assign stuff_err = bad_now;
    end
  endgenerate

  // R7: the error indication is a single-cycle pulse
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |=> !stuff_err);

endmodule

// File: rtl/fd_crc_fixstuff.sv
module fd_crc_fixstuff
  import fdfs_pkg::*;
#(
  parameter int unsigned LEN_S   = 17,
  parameter int unsigned LEN_L   = 21,
  parameter int unsigned GRP     = 4,
  parameter bit          ERR_REG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic bit_stb,
  input  logic crc_act,
  input  logic crc_len21,
  input  logic ser_in,
  output logic tx_bit,
  output logic tx_stall,
  output logic rx_crc_bit,
  output logic rx_crc_vld,
  output logic stuff_err
);
  slot_e slot_w;
  logic  ev_stuff_w;
  logic  ev_data_w;
  logic  line_q;

  fdfs_slot_ctr #(.LEN_S(LEN_S), .LEN_L(LEN_L), .GRP(GRP)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_stb  (bit_stb),
    .crc_act  (crc_act),
    .crc_len21(crc_len21),
    .slot     (slot_w),
    .ev_stuff (ev_stuff_w),
    .ev_data  (ev_data_w)
  );

  fdfs_tx_ins u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .bit_stb (bit_stb),
    .slot    (slot_w),
    .ser_in  (ser_in),
    .line_q  (line_q),
    .tx_bit  (tx_bit),
    .tx_stall(tx_stall)
  );

  fdfs_rx_chk #(.ERR_REG(ERR_REG)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (!tx_en),
    .ev_stuff  (ev_stuff_w),
    .ev_data   (ev_data_w),
    .ser_in    (ser_in),
    .line_q    (line_q),
    .rx_crc_bit(rx_crc_bit),
    .rx_crc_vld(rx_crc_vld),
    .stuff_err (stuff_err)
  );

  // previous line bit: emitted bit when sending, sampled bit when receiving
  always_ff @(posedge clk) begin
    if (!rst_n)       line_q <= 1'b1;
    else if (bit_stb) line_q <= tx_en ? tx_bit : ser_in;
  end

  // R6: receive strobes only accompany a bit strobe inside a receive field
  p_vld_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_vld |-> bit_stb && crc_act && !tx_en);

  // R4: no hold request outside an open transmit field
  p_stall_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stall |-> crc_act && tx_en);

  // R2: an inserted bit always changes the line level
  p_stuff_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && tx_stall |=> line_q != $past(line_q));

endmodule

// File: tb/sim_fd_crc_fixstuff.sv
`timescale 1ns/1ps
module sim_fd_crc_fixstuff;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b1, bit_stb = 1'b0, crc_act = 1'b0, crc_len21 = 1'b0, ser_in = 1'b0;
  logic tx_bit, tx_stall, rx_crc_bit, rx_crc_vld, stuff_err;

  int total = 0, bad = 0;
  logic b_last = 1'b1;   // bench view of the previous line bit
  int   k = 0;           // strobes seen in the current field
  int   blen = 17;
  int   nstall = 0, nerr = 0;
  bit   fin = 1'b0;

  always #5 clk = ~clk;

  fd_crc_fixstuff u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_stb(bit_stb), .crc_act(crc_act),
    .crc_len21(crc_len21), .ser_in(ser_in), .tx_bit(tx_bit), .tx_stall(tx_stall),
    .rx_crc_bit(rx_crc_bit), .rx_crc_vld(rx_crc_vld), .stuff_err(stuff_err)
  );

  // 0 = stuff, 1 = data, 2 = field complete
  function automatic int bkind(input int pos, input int len);
    int nst = (len + 3) / 4;
    if (pos >= len + nst) return 2;
    if (pos % 5 == 0) return 0;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic gap_cycle();
    int kd;
    @(negedge clk); bit_stb = 1'b0; #1;
    kd = crc_act ? bkind(k, blen) : -1;
    chk(stuff_err == 1'b0, "R7 gap err", stuff_err, 0);
    chk(tx_stall == (tx_en && kd == 0), "R4 gap stall", tx_stall, int'(tx_en && kd == 0));
    chk(rx_crc_vld == 1'b0, "R6 gap vld", rx_crc_vld, 0);
  endtask

  task automatic strobe(input logic act, input logic b, input int gaps);
    int kd; logic eb, ee;
    @(negedge clk);
    crc_act = act; ser_in = b; bit_stb = 1'b1;
    #1;
    kd = act ? bkind(k, blen) : -1;
    eb = (tx_en && kd == 0) ? ~b_last : b;
    ee = !tx_en && kd == 0 && (b == b_last);
    chk(tx_bit == eb, (kd == 0) ? "R2 stuff value" : "R3 pass through", tx_bit, eb);
    chk(tx_stall == (tx_en && kd == 0), "R4 stall", tx_stall, int'(tx_en && kd == 0));
    chk(rx_crc_vld == (!tx_en && kd == 1), "R6 vld", rx_crc_vld, int'(!tx_en && kd == 1));
    if (!tx_en && kd == 1) chk(rx_crc_bit == b, "R6 data bit", rx_crc_bit, b);
    if (tx_stall) nstall++;
    b_last = tx_en ? eb : b;
    k = act ? k + 1 : 0;
    @(negedge clk); bit_stb = 1'b0; #1;
    chk(stuff_err == ee, "R7 err", stuff_err, ee);
    if (stuff_err) nerr++;
    for (int g = 0; g < gaps; g++) gap_cycle();
  endtask

  // one CRC field; bad_pct is the chance of a wrong stuff bit in receive mode
  task automatic run_field(input logic mode, input logic l21, input int pre, input int extra,
                           input int bad_pct, input int gmax, input int abort_at);
    int n;
    logic b;
    tx_en = mode; crc_len21 = l21; blen = l21 ? 21 : 17;
    for (int i = 0; i < pre; i++) strobe(1'b0, 1'($urandom % 2), int'($urandom % (gmax + 1)));
    nstall = 0; nerr = 0;
    n = blen + (blen + 3) / 4 + extra;
    for (int i = 0; i < n; i++) begin
      if (i == abort_at) break;
      b = 1'($urandom % 2);
      if (!mode && bkind(k, blen) == 0)
        b = (int'($urandom % 100) < bad_pct) ? b_last : ~b_last;
      strobe(1'b1, b, int'($urandom % (gmax + 1)));
    end
    strobe(1'b0, 1'b1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(tx_stall == 1'b0, "R9 reset stall", tx_stall, 0);
    chk(rx_crc_vld == 1'b0, "R9 reset vld", rx_crc_vld, 0);
    chk(stuff_err == 1'b0, "R9 reset err", stuff_err, 0);
    @(negedge clk); rst_n = 1'b1;

    // R9 + R2: first field right after reset, no earlier bit: stuff must be 0
    tx_en = 1'b1; crc_len21 = 1'b0; blen = 17;
    @(negedge clk); crc_act = 1'b1; #1;
    chk(tx_bit == 1'b0, "R9 recessive start", tx_bit, 0);
    run_field(1'b1, 1'b0, 0, 0, 0, 0, -1);
    chk(nstall == 5, "R1 stuff count 17", nstall, 5);

    run_field(1'b1, 1'b1, 2, 3, 0, 1, -1);
    chk(nstall == 6, "R5 stuff count 21", nstall, 6);

    // receive, clean stuff bits, trailing strobes past the end
    run_field(1'b0, 1'b1, 3, 4, 0, 2, -1);
    chk(nerr == 0, "R7 clean field", nerr, 0);

    // receive, every stuff bit wrong
    run_field(1'b0, 1'b0, 1, 0, 100, 0, -1);
    chk(nerr == 5, "R7 all stuff wrong", nerr, 5);

    // R8: abort mid-field, next field reopens with a stuff slot
    run_field(1'b1, 1'b1, 1, 0, 0, 1, 7);
    run_field(1'b1, 1'b0, 0, 0, 0, 0, -1);
    chk(nstall == 5, "R8 restart count", nstall, 5);

    for (int f = 0; f < 300; f++)
      run_field(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 4), int'($urandom % 3),
                30, 2, ($urandom % 5 == 0) ? int'($urandom % 20) : -1);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule